// File: doc/BRIEF.md
# Flow-Control Pause Message Scheduler

This block watches the fill levels of two local receive buffers: a regular buffer and a high-priority buffer. When a fill level rises above a fixed breach threshold, the block asks a downstream message transmitter to send a flow-control message to the far end. That message carries an 8-bit pause-time value. If the buffer stays over threshold, a refresh timer runs from the moment the message is granted. Each time the timer expires, the message is requested again, so the far end keeps pausing for as long as the congestion lasts. The two channels work independently. Each raises its own one-cycle breach and retransmit status pulses. When both channels want the transmitter at once, the priority channel is served first.

The transmit side is a request/grant handshake. The block holds its request until the transmitter grants it. It presents the channel and the pause value alongside the request. On the receive side, a small decoder turns an incoming flow-control message into a per-channel valid pulse with the raw time value. If such a message arrives while flow control is switched off, the decoder raises an error pulse instead.

Top module: `fc_msg_sched`

## Requirements
- R1: When `reg_fill` goes from not above to above `THRESH` (the input is sampled at a clock edge), `reg_breach_pls` is high for exactly one cycle after that edge, and `msg_req` is high from that same cycle.
- R2: The priority channel behaves as in R1 with `pri_fill` and `pri_breach_pls`, independently of the regular channel.
- R3: A pending request holds `msg_req` high until a grant is taken at a clock edge with `msg_gnt` high. `msg_chan` reads 1 for the priority channel and 0 for the regular channel. `msg_time` equals the selected channel's `pri_pause` or `reg_pause` input. With no request pending, `msg_req`, `msg_chan` and `msg_time` are all 0.
- R4: If both channels are pending, the priority channel is presented and granted first. The regular channel is presented in the cycle after that grant.
- R5: After a grant, a channel whose fill stays above `THRESH` raises its request again, together with a one-cycle retransmit pulse (`reg_retx_pls` / `pri_retx_pls`), exactly `REFRESH` cycles after the grant edge. While a request waits for its grant, the timer is stopped and no retransmit pulse occurs.
- R6: When a channel's fill drops to or below `THRESH`, any pending request of that channel is withdrawn after the next edge, and its timer is cleared. A later crossing starts a fresh breach (R1/R2).
- R7: A fill level exactly equal to `THRESH` is not a breach. It raises no pulse and no request.
- R8: When `rx_msg_vld` is sampled high with `fc_on` high, `rx_reg_vld` (for `rx_msg_chan`=0) or `rx_pri_vld` (for `rx_msg_chan`=1) is high for one cycle after that edge. `rx_time` then holds the sampled `rx_msg_time`.
- R9: When `rx_msg_vld` is sampled high with `fc_on` low, `rx_fc_err` is high for one cycle after that edge, and neither per-channel valid pulse is raised.
- R10: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc_on | input | 1 | Flow control enabled |
| reg_fill | input | FILL_W | Regular buffer fill level |
| pri_fill | input | FILL_W | Priority buffer fill level |
| reg_pause | input | 8 | Pause time sent in regular-channel messages |
| pri_pause | input | 8 | Pause time sent in priority-channel messages |
| msg_req | output | 1 | Message request to the transmitter |
| msg_chan | output | 1 | Requested channel, 1 = priority |
| msg_time | output | 8 | Pause time of the requested message |
| msg_gnt | input | 1 | Grant from the transmitter |
| reg_breach_pls | output | 1 | Regular buffer breach pulse |
| pri_breach_pls | output | 1 | Priority buffer breach pulse |
| reg_retx_pls | output | 1 | Regular message retransmit pulse |
| pri_retx_pls | output | 1 | Priority message retransmit pulse |
| rx_msg_vld | input | 1 | Incoming flow-control message valid |
| rx_msg_chan | input | 1 | Incoming message channel, 1 = priority |
| rx_msg_time | input | 8 | Incoming raw pause time |
| rx_reg_vld | output | 1 | Regular-channel message received pulse |
| rx_pri_vld | output | 1 | Priority-channel message received pulse |
| rx_time | output | 8 | Last received raw pause time |
| rx_fc_err | output | 1 | Message received while flow control off |

## Verification
A refresh timer that drifts by one count shows up as a request that reasserts one cycle early or late. It is caught at the first retransmit, `REFRESH` cycles after a grant. A stuck pending flag shows up as `msg_req` staying high after a grant, or staying high after the fill falls. Either is visible on the very next cycle. A wrong arbitration order or a lost regular request appears as a wrong `msg_chan` or `msg_time` in the cycle after a shared grant. A bad receive decode appears as a mis-steered valid or error pulse one cycle after the incoming message.

// File: rtl/fc_pkg.sv
package fc_pkg;
   localparam int N_CH   = 2;
   localparam int CH_REG = 0;
   localparam int CH_PRI = 1;
   localparam int TIME_W = 8;

   typedef struct packed {
      logic breach;
      logic retx;
   } fc_stat_t;
endpackage

// File: rtl/fc_chan_ctl.sv
module fc_chan_ctl #(
   parameter int FILL_W  = 7,
   parameter int THRESH  = 48,
   parameter int REFRESH = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill,
   input  logic              gnt,
   output logic              pend,
   output fc_pkg::fc_stat_t  stat
);
   localparam int TMR_W = (REFRESH > 2) ? $clog2(REFRESH) : 1;
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REFRESH - 1);

   logic             over;
   logic             lvl_q;
   logic [TMR_W-1:0] tmr;

   always_comb over = (fill > FILL_W'(THRESH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q       <= 1'b0;
         pend        <= 1'b0;
         tmr         <= '0;
         stat        <= '0;
      end else begin
         lvl_q       <= over;
         stat.breach <= over & ~lvl_q;
         stat.retx   <= 1'b0;
         if (!over) begin
            pend <= 1'b0;
            tmr  <= '0;
         end else if (!lvl_q) begin
            pend <= 1'b1;
            tmr  <= '0;
         end else if (gnt) begin
            pend <= 1'b0;
            tmr  <= '0;
         end else if (pend) begin
            tmr  <= '0;
         end else if (tmr == TMR_LAST) begin
            pend      <= 1'b1;
            stat.retx <= 1'b1;
            tmr       <= '0;
         end else begin
            tmr <= tmr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fc_arb.sv
module fc_arb #(
   parameter int N = 2
) (
   input  logic [N-1:0]         req,
   input  logic                 gnt_in,
   output logic                 any,
   output logic [$clog2(N)-1:0] sel,
   output logic [N-1:0]         gnt_out
);
   localparam int SEL_W = $clog2(N);

   always_comb begin
      any = 1'b0;
      sel = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            any = 1'b1;
            sel = SEL_W'(i);
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_gnt
      assign gnt_out[g] = gnt_in & any & (sel == SEL_W'(g));
   end
endmodule

// File: rtl/fc_rx_dec.sv
module fc_rx_dec #(
   parameter int TIME_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fc_on,
   input  logic              vld,
   input  logic              chan,
   input  logic [TIME_W-1:0] tval,
   output logic              reg_vld,
   output logic              pri_vld,
   output logic [TIME_W-1:0] tout,
   output logic              err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_vld <= 1'b0;
         pri_vld <= 1'b0;
         tout    <= '0;
         err     <= 1'b0;
      end else begin
         reg_vld <= vld & fc_on & ~chan;
         pri_vld <= vld & fc_on & chan;
         err     <= vld & ~fc_on;
         if (vld) tout <= tval;
      end
   end
endmodule

// File: rtl/fc_msg_sched.sv
module fc_msg_sched
   import fc_pkg::*;
#(
   parameter int FILL_W  = 7,
   parameter int THRESH  = 48,
   parameter int REFRESH = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fc_on,
   input  logic [FILL_W-1:0] reg_fill,
   input  logic [FILL_W-1:0] pri_fill,
   input  logic [7:0]        reg_pause,
   input  logic [7:0]        pri_pause,
   output logic              msg_req,
   output logic              msg_chan,
   output logic [7:0]        msg_time,
   input  logic              msg_gnt,
   output logic              reg_breach_pls,
   output logic              pri_breach_pls,
   output logic              reg_retx_pls,
   output logic              pri_retx_pls,
   input  logic              rx_msg_vld,
   input  logic              rx_msg_chan,
   input  logic [7:0]        rx_msg_time,
   output logic              rx_reg_vld,
   output logic              rx_pri_vld,
   output logic [7:0]        rx_time,
   output logic              rx_fc_err
);
   localparam int SEL_W = $clog2(N_CH);

   if (THRESH >= (2 ** FILL_W)) begin : g_chk_thresh
      $error("THRESH does not fit in FILL_W bits");
   end
   if (REFRESH < 2) begin : g_chk_refresh
      $error("REFRESH must be at least 2");
   end

   logic [FILL_W-1:0] fill_a  [N_CH];
   logic [7:0]        pause_a [N_CH];
   logic [N_CH-1:0]   pend;
   logic [N_CH-1:0]   gnt_v;
   fc_stat_t          stat    [N_CH];
   logic              arb_any;
   logic [SEL_W-1:0]  arb_sel;

   assign fill_a[CH_REG]  = reg_fill;
   assign fill_a[CH_PRI]  = pri_fill;
   assign pause_a[CH_REG] = reg_pause;
   assign pause_a[CH_PRI] = pri_pause;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      fc_chan_ctl #(
         .FILL_W (FILL_W),
         .THRESH (THRESH),
         .REFRESH(REFRESH)
      ) u_ctl (
         .clk  (clk),
         .rst_n(rst_n),
         .fill (fill_a[c]),
         .gnt  (gnt_v[c]),
         .pend (pend[c]),
         .stat (stat[c])
      );
   end

   fc_arb #(.N(N_CH)) u_arb (
      .req    (pend),
      .gnt_in (msg_gnt),
      .any    (arb_any),
      .sel    (arb_sel),
      .gnt_out(gnt_v)
   );

   assign msg_req        = arb_any;
   assign msg_chan       = arb_any & (arb_sel == SEL_W'(CH_PRI));
   assign msg_time       = arb_any ? pause_a[arb_sel] : 8'h00;
   assign reg_breach_pls = stat[CH_REG].breach;
   assign pri_breach_pls = stat[CH_PRI].breach;
   assign reg_retx_pls   = stat[CH_REG].retx;
   assign pri_retx_pls   = stat[CH_PRI].retx;

   fc_rx_dec #(.TIME_W(TIME_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .fc_on  (fc_on),
      .vld    (rx_msg_vld),
      .chan   (rx_msg_chan),
      .tval   (rx_msg_time),
      .reg_vld(rx_reg_vld),
      .pri_vld(rx_pri_vld),
      .tout   (rx_time),
      .err    (rx_fc_err)
   );
endmodule

// File: rtl/fc_msg_sched_chk.sv
module fc_msg_sched_chk (
   input logic clk,
   input logic rst_n,
   input logic fc_on,
   input logic rx_msg_vld,
   input logic msg_req,
   input logic msg_chan,
   input logic reg_breach_pls,
   input logic pri_breach_pls,
   input logic reg_retx_pls,
   input logic pri_retx_pls,
   input logic rx_reg_vld,
   input logic rx_pri_vld,
   input logic rx_fc_err
);
   AST_REG_BREACH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      reg_breach_pls |-> msg_req); // R1
   AST_PRI_BREACH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      pri_breach_pls |-> (msg_req && msg_chan)); // R2
   AST_PRI_RETX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      pri_retx_pls |-> (msg_req && msg_chan)); // R4
   AST_REG_RETX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      reg_retx_pls |-> msg_req); // R5
   AST_RETX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_retx_pls |=> !reg_retx_pls); // R5
   AST_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_reg_vld || rx_pri_vld) |-> $past(rx_msg_vld && fc_on)); // R8
   AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_reg_vld, rx_pri_vld, rx_fc_err})); // R9
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fc_err |-> $past(rx_msg_vld && !fc_on)); // R9
endmodule

bind fc_msg_sched fc_msg_sched_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fc_on         (fc_on),
   .rx_msg_vld    (rx_msg_vld),
   .msg_req       (msg_req),
   .msg_chan      (msg_chan),
   .reg_breach_pls(reg_breach_pls),
   .pri_breach_pls(pri_breach_pls),
   .reg_retx_pls  (reg_retx_pls),
   .pri_retx_pls  (pri_retx_pls),
   .rx_reg_vld    (rx_reg_vld),
   .rx_pri_vld    (rx_pri_vld),
   .rx_fc_err     (rx_fc_err)
);

// File: tb/fc_msg_sched_tb_top.sv
module fc_msg_sched_tb_top;
   localparam int FW = 6;
   localparam int TH = 10;
   localparam int RF = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fc_on = 1'b1;
   logic [FW-1:0] reg_fill = '0, pri_fill = '0;
   logic [7:0]    reg_pause = '0, pri_pause = '0;
   logic          msg_req, msg_chan, msg_gnt = 1'b0;
   logic [7:0]    msg_time;
   logic          reg_breach_pls, pri_breach_pls, reg_retx_pls, pri_retx_pls;
   logic          rx_msg_vld = 1'b0, rx_msg_chan = 1'b0;
   logic [7:0]    rx_msg_time = '0;
   logic          rx_reg_vld, rx_pri_vld, rx_fc_err;
   logic [7:0]    rx_time;

   always #4 clk = ~clk;

   fc_msg_sched #(.FILL_W(FW), .THRESH(TH), .REFRESH(RF)) dut_i (
      .clk(clk), .rst_n(rst_n), .fc_on(fc_on),
      .reg_fill(reg_fill), .pri_fill(pri_fill),
      .reg_pause(reg_pause), .pri_pause(pri_pause),
      .msg_req(msg_req), .msg_chan(msg_chan), .msg_time(msg_time), .msg_gnt(msg_gnt),
      .reg_breach_pls(reg_breach_pls), .pri_breach_pls(pri_breach_pls),
      .reg_retx_pls(reg_retx_pls), .pri_retx_pls(pri_retx_pls),
      .rx_msg_vld(rx_msg_vld), .rx_msg_chan(rx_msg_chan), .rx_msg_time(rx_msg_time),
      .rx_reg_vld(rx_reg_vld), .rx_pri_vld(rx_pri_vld), .rx_time(rx_time),
      .rx_fc_err(rx_fc_err)
   );

   int total = 0;
   int bad   = 0;
   bit auto_gnt = 1'b0;

   // behavioural reference model
   int  m_prev [2] = '{0, 0};
   int  m_pend [2] = '{0, 0};
   int  m_cnt  [2] = '{0, 0};
   bit  m_bp   [2] = '{0, 0};
   bit  m_rt   [2] = '{0, 0};
   bit  m_rv   [2] = '{0, 0};
   bit  m_err = 1'b0;
   int  m_rtime = 0;
   bit  take [2];
   int  lvl  [2];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_prev[c] = 0; m_pend[c] = 0; m_cnt[c] = 0;
            m_bp[c] = 0; m_rt[c] = 0; m_rv[c] = 0;
         end
         m_err = 0; m_rtime = 0;
      end else begin
         lvl[0] = int'(reg_fill);
         lvl[1] = int'(pri_fill);
         take[1] = msg_gnt && (m_pend[1] != 0);
         take[0] = msg_gnt && (m_pend[0] != 0) && (m_pend[1] == 0);
         for (int c = 0; c < 2; c++) begin
            m_bp[c] = (lvl[c] > TH) && (m_prev[c] == 0);
            m_rt[c] = 1'b0;
            if (lvl[c] <= TH) begin
               m_pend[c] = 0; m_cnt[c] = 0;
            end else if (m_prev[c] == 0) begin
               m_pend[c] = 1; m_cnt[c] = 0;
            end else if (take[c]) begin
               m_pend[c] = 0; m_cnt[c] = 0;
            end else if (m_pend[c] != 0) begin
               m_cnt[c] = 0;
            end else begin
               m_cnt[c]++;
               if (m_cnt[c] == RF) begin
                  m_pend[c] = 1; m_rt[c] = 1'b1; m_cnt[c] = 0;
               end
            end
            m_prev[c] = (lvl[c] > TH) ? 1 : 0;
         end
         m_rv[0] = rx_msg_vld && fc_on && !rx_msg_chan;
         m_rv[1] = rx_msg_vld && fc_on && rx_msg_chan;
         m_err   = rx_msg_vld && !fc_on;
         if (rx_msg_vld) m_rtime = int'(rx_msg_time);
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      logic [7:0] et;
      et = (m_pend[1] != 0) ? pri_pause : ((m_pend[0] != 0) ? reg_pause : 8'h00);
      chk("R3 msg_req",         32'(msg_req),  32'(m_pend[0] != 0 || m_pend[1] != 0));
      chk("R3 msg_chan",        32'(msg_chan), 32'(m_pend[1] != 0));
      chk("R3 msg_time",        32'(msg_time), 32'(et));
      chk("R1 reg_breach_pls",  32'(reg_breach_pls), 32'(m_bp[0]));
      chk("R2 pri_breach_pls",  32'(pri_breach_pls), 32'(m_bp[1]));
      chk("R5 reg_retx_pls",    32'(reg_retx_pls), 32'(m_rt[0]));
      chk("R5 pri_retx_pls",    32'(pri_retx_pls), 32'(m_rt[1]));
      chk("R8 rx_reg_vld",      32'(rx_reg_vld), 32'(m_rv[0]));
      chk("R8 rx_pri_vld",      32'(rx_pri_vld), 32'(m_rv[1]));
      chk("R8 rx_time",         32'(rx_time), 32'(m_rtime));
      chk("R9 rx_fc_err",       32'(rx_fc_err), 32'(m_err));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_n) compare();
         msg_gnt = auto_gnt && msg_req;
      end
   endtask

   initial begin
      #(8 * 200000);
      total++; bad++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      chk("R10 msg_req",  32'(msg_req), 0);
      chk("R10 msg_time", 32'(msg_time), 0);
      chk("R10 pulses",   32'({reg_breach_pls, pri_breach_pls, reg_retx_pls, pri_retx_pls}), 0);
      chk("R10 rx",       32'({rx_reg_vld, rx_pri_vld, rx_fc_err, rx_time}), 0);

      // R1/R5: regular breach with prompt grants and refresh
      reg_pause = 8'h3C; auto_gnt = 1'b1; reg_fill = 6'd11;
      step(1);
      chk("R1 breach pulse", 32'(reg_breach_pls), 1);
      chk("R1 request", 32'(msg_req), 1);
      step(70);

      // R7: level equal to threshold
      reg_fill = 6'd10;
      step(25);
      chk("R7 no request at threshold", 32'(msg_req), 0);
      chk("R7 no breach at threshold", 32'(reg_breach_pls), 0);

      // R4: both channels cross together, grants withheld
      auto_gnt = 1'b0; pri_pause = 8'hA5; reg_pause = 8'h11;
      reg_fill = 6'd40; pri_fill = 6'd40;
      step(1);
      chk("R4 priority presented first", 32'(msg_chan), 1);
      chk("R4 priority time", 32'(msg_time), 32'h A5);
      step(30);
      chk("R5 no retransmit while waiting", 32'(pri_retx_pls | reg_retx_pls), 0);
      msg_gnt = 1'b1;
      step(1);
      chk("R4 regular after priority", 32'(msg_chan), 0);
      chk("R4 regular still requested", 32'(msg_req), 1);
      chk("R4 regular time", 32'(msg_time), 32'h11);
      auto_gnt = 1'b1;
      step(80);

      // R6: breach clears while requests wait
      auto_gnt = 1'b0;
      step(20);
      reg_fill = 6'd3; pri_fill = 6'd0;
      step(2);
      chk("R6 request withdrawn", 32'(msg_req), 0);
      pri_fill = 6'd12;
      step(1);
      chk("R6 fresh priority breach", 32'(pri_breach_pls), 1);
      pri_fill = 6'd0;
      step(3);

      // R8/R9: receive decode
      rx_msg_vld = 1'b1; rx_msg_chan = 1'b0; rx_msg_time = 8'h22;
      step(1);
      chk("R8 regular received", 32'(rx_reg_vld), 1);
      chk("R8 regular time", 32'(rx_time), 32'h22);
      rx_msg_chan = 1'b1; rx_msg_time = 8'h77;
      step(1);
      chk("R8 priority received", 32'(rx_pri_vld), 1);
      chk("R8 priority time", 32'(rx_time), 32'h77);
      rx_msg_vld = 1'b0;
      step(2);
      fc_on = 1'b0; rx_msg_vld = 1'b1; rx_msg_time = 8'h99;
      step(1);
      chk("R9 error raised", 32'(rx_fc_err), 1);
      chk("R9 no valid", 32'(rx_pri_vld | rx_reg_vld), 0);
      rx_msg_vld = 1'b0;
      step(3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule